// File: doc/BRIEF.md
# Page-Offset-Indexed Physically Tagged Cache

This block is a 4 KB direct-mapped data cache with one 32-bit word per line. It takes its line index only from the untranslated page offset of a request. The array read can therefore start while the translation buffer is still producing the physical frame number. The two paths meet only at the tag compare, which matches the stored physical frame number against the translated one.

A requester presents a page offset, a read/write flag and write data. In the same cycle the translation buffer presents a translation-valid flag and a 20-bit physical page number. The lookup result comes back one cycle later.

A read miss with a valid translation fetches one word over a simple request/acknowledge memory port and fills the line. Writes go through to memory, and a write that misses does not allocate a line. While a memory transaction is outstanding the block raises `busy` and ignores new requests. An elaboration-time check rejects any size whose index and byte-select bits would run past the page offset.

Top module: `overlap_cache`

## Requirements
- R1: After reset every line is invalid: the first read of any line with a valid translation reports a miss, and `rsp_valid`, `busy` and `mem_req` are low out of reset.
- R2: Offset bits 11:2 select one of 1024 lines and bits 1:0 have no effect on lookup or memory address. The stored tag is the 20-bit physical page number, so two pages that share an index evict each other.
- R3: A request is accepted when `req_valid` is high and `busy` is low. In the following cycle `rsp_valid` is high, and `rsp_hit` is high exactly when the translation is valid, the line is valid and its tag equals `xlat_ppn`. On a read hit, `rsp_rdata` carries the line's word.
- R4: A request with `xlat_valid` low responds with `rsp_fault` high and `rsp_hit` low. It issues no memory request and changes no line.
- R5: A read miss with a valid translation responds with `rsp_hit` low. From that same cycle it holds `mem_req` high with `mem_we` low and `mem_addr` = {ppn, offset[11:2], 2'b00} until `mem_ack`, with `busy` high throughout. `busy` and `mem_req` are low in the cycle after the acknowledge.
- R6: In the cycle after a read fill is acknowledged, `rsp_valid` and `rsp_hit` are high and `rsp_rdata` equals the acknowledged `mem_rdata`. Later reads of that line with the same page then hit with that word.
- R7: A write with a valid translation always issues a memory write with the same address rule and `mem_wdata` equal to the request data. On a hit the line takes the new word; on a miss no line is allocated. No second response follows the write's acknowledge.
- R8: Requests presented while `busy` is high are ignored. They produce no response and do not change any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_vofs | input | 12 | Untranslated page offset |
| req_wdata | input | 32 | Write data |
| xlat_valid | input | 1 | Translation buffer found a mapping |
| xlat_ppn | input | 20 | Translated physical page number |
| busy | output | 1 | Memory transaction outstanding; requests ignored |
| rsp_valid | output | 1 | Lookup or fill result present |
| rsp_hit | output | 1 | Result is a hit / fill data |
| rsp_fault | output | 1 | Request had no valid translation |
| rsp_rdata | output | 32 | Read word (zero unless a read hit or fill) |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Physical word address of the memory request |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
A lookup result is due one clock edge after acceptance. The bench drives each request before an edge and samples the response at the following falling edge, at which point the matching memory request must already be up. The memory model waits a chosen number of cycles and then acknowledges. The fill response, or for writes the absence of one, is checked at the falling edge right after the acknowledging edge, together with `busy` dropping. Every check compares against a reference line table kept in the bench, so hits, misses, evictions and fault cases are all predicted before they are observed.

// File: rtl/overlap_cache_pkg.sv
package overlap_cache_pkg;

  // A line holds exactly one machine word.
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_MEM  = 1'b1
  } ctl_state_e;

endpackage

// File: rtl/oc_tag_store.sv
module oc_tag_store #(
  parameter int unsigned LINES   = 1024,
  parameter int unsigned INDEX_W = 10,
  parameter int unsigned TAG_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_index,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag
);

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] vld_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_index] = 1'b1;
  end

  // Valid bits are the only reset state of the array.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_index] <= wr_tag;
  end

  assign rd_valid = vld_q[rd_index];
  assign rd_tag   = tag_q[rd_index];

  // A filled line reads back valid with its new tag on the next cycle.
  p_fill_marks_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_index)] && tag_q[$past(wr_index)] == $past(wr_tag)));

endmodule

// File: rtl/oc_data_store.sv
module oc_data_store #(
  parameter int unsigned LINES   = 1024,
  parameter int unsigned INDEX_W = 10,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] rd_index,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [DATA_W-1:0]  wr_data
);

  logic [DATA_W-1:0] word_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_index] <= wr_data;
  end

  assign rd_data = word_q[rd_index];

endmodule

// File: rtl/oc_miss_ctrl.sv
module oc_miss_ctrl
  import overlap_cache_pkg::*;
#(
  parameter int unsigned INDEX_W = 10,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned BSEL_W  = 2,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ADDR_W = TAG_W + INDEX_W + BSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  // lookup stage
  input  logic               accept,
  input  logic               req_write,
  input  logic               xlat_valid,
  input  logic               tag_hit,
  input  logic [INDEX_W-1:0] lk_index,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [DATA_W-1:0]  lk_data,
  input  logic [DATA_W-1:0]  req_wdata,
  // response
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic [DATA_W-1:0]  rsp_rdata,
  // memory port
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  // line refill
  output logic               fill_we,
  output logic [INDEX_W-1:0] fill_index,
  output logic [TAG_W-1:0]   fill_tag,
  output logic [DATA_W-1:0]  fill_data
);

  ctl_state_e        state_q, state_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic              rsp_fault_q, rsp_fault_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  logic               pend_load;
  logic               pend_we_q;
  logic [INDEX_W-1:0] pend_index_q;
  logic [TAG_W-1:0]   pend_tag_q;
  logic [DATA_W-1:0]  pend_wdata_q;

  logic mem_done;
  assign mem_done = (state_q == CTL_MEM) && mem_ack;

  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = 1'b0;
    rsp_fault_d = 1'b0;
    rsp_rdata_d = '0;
    pend_load   = 1'b0;
    unique case (state_q)
      CTL_IDLE: begin
        if (accept) begin
          rsp_valid_d = 1'b1;
          rsp_fault_d = !xlat_valid;
          rsp_hit_d   = tag_hit;
          if (tag_hit && !req_write) rsp_rdata_d = lk_data;
          // Every translated write goes to memory; a translated read only on a miss.
          if (xlat_valid && (req_write || !tag_hit)) begin
            state_d   = CTL_MEM;
            pend_load = 1'b1;
          end
        end
      end
      CTL_MEM: begin
        if (mem_ack) begin
          state_d = CTL_IDLE;
          if (!pend_we_q) begin
            rsp_valid_d = 1'b1;
            rsp_hit_d   = 1'b1;
            rsp_rdata_d = mem_rdata;
          end
        end
      end
      default: state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CTL_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  // Pending transaction: loaded only on the accepting cycle, so no reset needed.
  always_ff @(posedge clk) begin
    if (pend_load) begin
      pend_we_q    <= req_write;
      pend_index_q <= lk_index;
      pend_tag_q   <= lk_tag;
      pend_wdata_q <= req_wdata;
    end
  end

  assign busy       = (state_q == CTL_MEM);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_fault  = rsp_fault_q;
  assign rsp_rdata  = rsp_rdata_q;

  assign mem_req    = (state_q == CTL_MEM);
  assign mem_we     = pend_we_q;
  assign mem_addr   = {pend_tag_q, pend_index_q, {BSEL_W{1'b0}}};
  assign mem_wdata  = pend_wdata_q;

  assign fill_we    = mem_done && !pend_we_q;
  assign fill_index = pend_index_q;
  assign fill_tag   = pend_tag_q;
  assign fill_data  = mem_rdata;

  p_fault_never_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !rsp_hit);

  p_fault_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !xlat_valid) |=> !mem_req);

  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_fill_returns_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (rsp_valid && rsp_hit && rsp_rdata == $past(mem_rdata)));

  p_write_ack_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> (!rsp_valid && !busy));

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> !rsp_valid);

endmodule

// File: rtl/overlap_cache.sv
module overlap_cache
  import overlap_cache_pkg::*;
#(
  parameter int unsigned CACHE_BYTES = 4096,
  parameter int unsigned PAGE_OFS_W  = 12,
  parameter int unsigned PPN_W       = 20,
  localparam int unsigned DATA_W  = WORD_W,
  localparam int unsigned BSEL_W  = $clog2(WORD_BYTES),
  localparam int unsigned LINES   = CACHE_BYTES / WORD_BYTES,
  localparam int unsigned INDEX_W = $clog2(LINES),
  localparam int unsigned OFS_W   = INDEX_W + BSEL_W,
  localparam int unsigned PA_W    = PPN_W + PAGE_OFS_W,
  localparam int unsigned TAG_W   = PA_W - OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [PAGE_OFS_W-1:0] req_vofs,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  xlat_valid,
  input  logic [PPN_W-1:0]      xlat_ppn,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_fault,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [PA_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata
);

  // Overlap only works while index and byte select sit inside the page offset.
  generate
    if (OFS_W > PAGE_OFS_W) begin : g_size_too_large
      $error("cache index and byte select exceed the untranslated page offset");
    end
  endgenerate

  // Physical address as seen at the compare; offset part is untranslated.
  logic [PA_W-1:0]    pa_lk;
  logic [INDEX_W-1:0] lk_index;
  logic [TAG_W-1:0]   lk_tag;
  logic [BSEL_W-1:0]  unused_bsel;

  assign pa_lk       = {xlat_ppn, req_vofs};
  assign lk_index    = pa_lk[OFS_W-1:BSEL_W];
  assign lk_tag      = pa_lk[PA_W-1:OFS_W];
  assign unused_bsel = pa_lk[BSEL_W-1:0];

  logic accept;
  assign accept = req_valid && !busy;

  // Array reads depend on the offset only and run beside translation.
  logic               st_valid;
  logic [TAG_W-1:0]   st_tag;
  logic [DATA_W-1:0]  st_data;
  logic               tag_hit;

  logic               fill_we;
  logic [INDEX_W-1:0] fill_index;
  logic [TAG_W-1:0]   fill_tag;
  logic [DATA_W-1:0]  fill_data;

  assign tag_hit = xlat_valid && st_valid && (st_tag == lk_tag);

  logic               wr_hit;
  logic               dwr_en;
  logic [INDEX_W-1:0] dwr_index;
  logic [DATA_W-1:0]  dwr_data;

  assign wr_hit    = accept && req_write && tag_hit;
  assign dwr_en    = fill_we || wr_hit;
  assign dwr_index = fill_we ? fill_index : lk_index;
  assign dwr_data  = fill_we ? fill_data  : req_wdata;

  oc_tag_store #(
    .LINES   (LINES),
    .INDEX_W (INDEX_W),
    .TAG_W   (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_index (lk_index),
    .rd_valid (st_valid),
    .rd_tag   (st_tag),
    .wr_en    (fill_we),
    .wr_index (fill_index),
    .wr_tag   (fill_tag)
  );

  oc_data_store #(
    .LINES   (LINES),
    .INDEX_W (INDEX_W),
    .DATA_W  (DATA_W)
  ) u_data (
    .clk      (clk),
    .rd_index (lk_index),
    .rd_data  (st_data),
    .wr_en    (dwr_en),
    .wr_index (dwr_index),
    .wr_data  (dwr_data)
  );

  oc_miss_ctrl #(
    .INDEX_W (INDEX_W),
    .TAG_W   (TAG_W),
    .BSEL_W  (BSEL_W),
    .DATA_W  (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (req_write),
    .xlat_valid (xlat_valid),
    .tag_hit    (tag_hit),
    .lk_index   (lk_index),
    .lk_tag     (lk_tag),
    .lk_data    (st_data),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_rdata  (rsp_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .fill_we    (fill_we),
    .fill_index (fill_index),
    .fill_tag   (fill_tag),
    .fill_data  (fill_data)
  );

  // Refill and write-hit update never compete for the single data write port.
  p_one_data_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && wr_hit));

  // Nothing is accepted while a transaction is open.
  p_no_lookup_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_hit);

endmodule

// File: tb/overlap_cache_tb.sv
module overlap_cache_tb;

  localparam int NL = 1024;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_vofs;
  logic [31:0] req_wdata;
  logic        xlat_valid;
  logic [19:0] xlat_ppn;
  logic        busy, rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  overlap_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_vofs(req_vofs),
    .req_wdata(req_wdata), .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  // Reference line table, built from the requirements.
  bit          ev [NL];
  logic [19:0] et [NL];
  logic [31:0] ed [NL];

  logic [11:0] inj_ofs;
  logic [19:0] inj_ppn;

  function automatic logic [31:0] memval(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      report();
      $finish;
    end
  end

  // One complete request, including any memory transaction it causes.
  task automatic access(input bit w, input logic [11:0] ofs, input logic [19:0] ppn,
                        input bit xv, input logic [31:0] wd, input int lat, input bit inject);
    logic [9:0]  idx;
    bit          exp_hit;
    bit          exp_mem;
    logic [31:0] exp_addr;
    logic [31:0] fv;
    idx      = ofs[11:2];
    exp_hit  = xv && ev[idx] && (et[idx] == ppn);
    exp_mem  = xv && (w || !exp_hit);
    exp_addr = {ppn, idx, 2'b00};

    @(negedge clk);
    chk("R8 idle before request", busy, 0);
    req_valid = 1; req_write = w; req_vofs = ofs; req_wdata = wd;
    xlat_valid = xv; xlat_ppn = ppn;
    @(negedge clk);
    req_valid = 0;
    chk("R3 response one cycle after accept", rsp_valid, 1);
    chk("R4 fault flag", rsp_fault, !xv);
    chk(exp_hit ? "R3 hit" : (xv ? "R1 R2 R5 miss" : "R4 fault suppresses hit"), rsp_hit, exp_hit);
    if (exp_hit && !w) chk("R3 hit data", rsp_rdata, ed[idx]);
    if (w && exp_hit) ed[idx] = wd;

    if (!exp_mem) begin
      chk(xv ? "R3 no memory on read hit" : "R4 no memory on fault", mem_req, 0);
    end else begin
      chk("R5 R7 request raised", mem_req, 1);
      chk("R5 R7 request kind", mem_we, w);
      chk("R2 R5 R7 request address", mem_addr, exp_addr);
      if (w) chk("R7 write-through data", mem_wdata, wd);
      for (int k = 0; k < lat; k++) begin
        if (inject && k == 0) begin
          req_valid = 1; req_write = 1; req_vofs = inj_ofs;
          req_wdata = 32'hDEAD_BEEF; xlat_valid = 1; xlat_ppn = inj_ppn;
        end
        @(negedge clk);
        req_valid = 0;
        chk("R5 request held", {mem_req, busy, mem_addr}, {2'b11, exp_addr});
        chk("R8 no response while busy", rsp_valid, 0);
      end
      fv = memval(exp_addr);
      mem_ack = 1; mem_rdata = fv;
      @(negedge clk);
      mem_ack = 0; mem_rdata = '0;
      if (!w) begin
        chk("R6 fill response", {rsp_valid, rsp_hit}, 2'b11);
        chk("R6 fill data", rsp_rdata, fv);
        ev[idx] = 1; et[idx] = ppn; ed[idx] = fv;
      end else begin
        chk("R7 no response after write ack", rsp_valid, 0);
      end
      chk("R5 released after ack", {busy, mem_req}, 2'b00);
    end
  endtask

  localparam logic [19:0] PA = 20'h12345;
  localparam logic [19:0] PB = 20'hABCDE;
  localparam logic [19:0] PC = 20'h0F0F0;
  localparam logic [19:0] PD = 20'h77001;

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_vofs = '0; req_wdata = '0;
    xlat_valid = 0; xlat_ppn = '0; mem_ack = 0; mem_rdata = '0;
    inj_ofs = '0; inj_ppn = '0;
    for (int i = 0; i < NL; i++) begin ev[i] = 0; et[i] = '0; ed[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rsp_valid, busy, mem_req}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {rsp_valid, busy, mem_req}, 3'b000);

    // R1 R5 R6: every line misses once and is filled, byte bits varied.
    for (int i = 0; i < NL; i++)
      access(0, {i[9:0], i[1:0]}, PA, 1, 0, i % 3, 0);

    // R2 R3: every line now hits, with the other byte-select values.
    for (int i = 0; i < NL; i++)
      access(0, {i[9:0], ~i[1:0]}, PA, 1, 0, 0, 0);

    // R4: no translation, reads and writes; line content must survive.
    for (int i = 0; i < NL; i += 97) begin
      access(0, {i[9:0], 2'b00}, PA, 0, 0, 0, 0);
      access(1, {i[9:0], 2'b01}, PA, 0, 32'h5555_0000 + i, 0, 0);
      access(0, {i[9:0], 2'b10}, PA, 1, 0, 0, 0);
    end

    // R2: another page on the same index evicts, then the first page misses again.
    for (int i = 3; i < NL; i += 61) begin
      access(0, {i[9:0], 2'b00}, PB, 1, 0, 1, 0);
      access(0, {i[9:0], 2'b00}, PA, 1, 0, 2, 0);
      access(0, {i[9:0], 2'b11}, PA, 1, 0, 0, 0);
    end

    // R7: write hit updates the line; write miss leaves it untouched.
    for (int i = 5; i < NL; i += 53) begin
      access(1, {i[9:0], 2'b00}, PA, 1, i * 7 + 3, i % 3, 0);
      access(0, {i[9:0], 2'b00}, PA, 1, 0, 0, 0);
      access(1, {i[9:0], 2'b00}, PC, 1, 32'hCAFE_0000 + i, 1, 0);
      access(0, {i[9:0], 2'b00}, PA, 1, 0, 0, 0);
      access(0, {i[9:0], 2'b00}, PC, 1, 0, 1, 0);
    end

    // R8: a write aimed at a valid line while busy must not land or respond.
    for (int j = 0; j < 6; j++) begin
      inj_ofs = {10'(200 + j), 2'b00};
      inj_ppn = PA;
      access(0, {10'(700 + j), 2'b00}, PD, 1, 0, 2, 1);
      access(0, inj_ofs, PA, 1, 0, 0, 0);
    end

    report();
    $finish;
  end

endmodule